// File: doc/BRIEF.md
# Link Fault Status Controller

This block sits between the MAC and the PCS on a 32-bit, four-lane media independent interface running at 10 Gb/s. It watches every receive word for a link status ordered set: a sequence control character in the lowest lane, two zero bytes, and a status code in the top lane. A fault state is entered only after the same fault has been seen several times in close succession. The state is left again once the status sets have been absent for a long enough run of words.

While the block holds the local fault state, it replaces the MAC's transmit words with remote fault ordered sets, so that the link partner learns that this end cannot receive. While it holds the remote fault state, it sends idle words instead of MAC data. In the link-good state, the MAC transmit words pass through with one register of latency. Two registered flags report the current state.

Top module: `link_fault_ctrl`

## Requirements
- R1: A receive word is a local fault set when rx_ctrl is 4'b0001 and rx_data is 32'h0100009C. It is a remote fault set when rx_ctrl is 4'b0001 and rx_data is 32'h0200009C. Lane 0 is bits 7:0 and holds the sequence character 0x9C. Lane 3 is bits 31:24 and holds the code. Every other word is a non-fault word, including one with a nonzero byte in lane 1 or 2 and one with any other control pattern.
- R2: local_fault rises on the clock edge that samples the fourth local fault set of an unbroken run. Three sets are not enough.
- R3: A run continues across gaps of up to 127 non-fault words between two sets of the same type. A gap of 128 non-fault words ends the run, and the next set starts a new count at one.
- R4: A fault set of the other type restarts the count at one for that type. While a fault state is held, the flags do not change until four sets of the new type complete a run.
- R5: After 128 consecutive non-fault words, both flags clear on the edge that samples the 128th word.
- R6: While local_fault is high, tx_data is 32'h0200009C and tx_ctrl is 4'b0001.
- R7: While remote_fault is high, tx_data is 32'h07070707 and tx_ctrl is 4'hF.
- R8: While neither flag is high, tx_data and tx_ctrl equal mac_txd and mac_txc as sampled on the previous clock edge. The outputs switch on the same edge as the flags.
- R9: An asynchronous active-low reset clears both flags and sets the transmit outputs to idle (32'h07070707, 4'hF).
- R10: local_fault and remote_fault are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Receive word, lane 0 in bits 7:0 |
| rx_ctrl | input | 4 | Receive control flag per lane |
| mac_txd | input | 32 | Transmit word from the MAC |
| mac_txc | input | 4 | Transmit control flags from the MAC |
| tx_data | output | 32 | Transmit word toward the PCS |
| tx_ctrl | output | 4 | Transmit control flags toward the PCS |
| local_fault | output | 1 | Local fault state held |
| remote_fault | output | 1 | Remote fault state held |

## Verification
On every cycle, the assertions check that the two flags are exclusive and that each flag matches the transmit word it forces. They also check that the link-good state passes the MAC word through with one cycle of delay, and that a flag can rise only on a cycle that sampled a matching fault set. The counting behaviour can only be shown by the bench's scenarios: the fourth set triggers the fault while the third does not, the 127-word gap is accepted while the 128-word gap is not, a mixed-type run restarts the count, and the state returns to good on exactly the 128th quiet word.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int LANES = 4;
    localparam int DW    = LANES * 8;

    localparam logic [7:0] SEQ_CHAR    = 8'h9C;
    localparam logic [7:0] IDLE_CHAR   = 8'h07;
    localparam logic [7:0] CODE_LOCAL  = 8'h01;
    localparam logic [7:0] CODE_REMOTE = 8'h02;

    typedef enum logic [1:0] {
        SEQ_NONE   = 2'd0,
        SEQ_LOCAL  = 2'd1,
        SEQ_REMOTE = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        LINK_OK     = 2'd0,
        LINK_LOCAL  = 2'd1,
        LINK_REMOTE = 2'd2
    } link_e;
endpackage

// File: rtl/lfc_seq_decode.sv
module lfc_seq_decode
    import lfc_pkg::*;
(
    input  logic [DW-1:0]    rx_data,
    input  logic [LANES-1:0] rx_ctrl,
    output seq_e             kind
);
    localparam int MID = LANES - 2;

    logic [MID-1:0] mid_zero;
    logic           ctrl_ok;
    logic           char_ok;
    logic [7:0]     code;

    genvar g;
    generate
        for (g = 0; g < MID; g++) begin : g_mid
            assign mid_zero[g] = (rx_data[(g+1)*8 +: 8] == 8'h00);
        end
    endgenerate

    assign ctrl_ok = (rx_ctrl == {{(LANES-1){1'b0}}, 1'b1});
    assign char_ok = (rx_data[7:0] == SEQ_CHAR);
    assign code    = rx_data[DW-1 -: 8];

    always_comb begin
        kind = SEQ_NONE;
        if (ctrl_ok && char_ok && (&mid_zero)) begin
            if (code == CODE_LOCAL)       kind = SEQ_LOCAL;
            else if (code == CODE_REMOTE) kind = SEQ_REMOTE;
        end
    end
endmodule

// File: rtl/lfc_fault_fsm.sv
module lfc_fault_fsm
    import lfc_pkg::*;
#(
    parameter int QUAL_CNT  = 4,
    parameter int CLEAR_GAP = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  seq_e  kind,
    output link_e link_next,
    output link_e link_cur
);
    localparam int CW = $clog2(QUAL_CNT + 1);
    localparam int GW = $clog2(CLEAR_GAP + 1);

    typedef struct packed {
        link_e         link;
        seq_e          run;
        logic [CW-1:0] cnt;
        logic [GW-1:0] gap;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kind == SEQ_NONE) begin
            if (st_q.gap != GW'(CLEAR_GAP)) begin
                st_d.gap = st_q.gap + 1'b1;
                if (st_d.gap == GW'(CLEAR_GAP)) begin
                    st_d.cnt  = '0;
                    st_d.run  = SEQ_NONE;
                    st_d.link = LINK_OK;
                end
            end
        end else begin
            st_d.gap = '0;
            if (kind == st_q.run && st_q.cnt != '0) begin
                if (st_q.cnt != CW'(QUAL_CNT)) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.run = kind;
                st_d.cnt = CW'(1);
            end
            if (st_d.cnt == CW'(QUAL_CNT)) begin
                st_d.link = (kind == SEQ_LOCAL) ? LINK_LOCAL : LINK_REMOTE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{link: LINK_OK, run: SEQ_NONE, cnt: '0, gap: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign link_next = st_d.link;
    assign link_cur  = st_q.link;
endmodule

// File: rtl/lfc_tx_mux.sv
module lfc_tx_mux
    import lfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  link_e            link_next,
    input  logic [DW-1:0]    mac_txd,
    input  logic [LANES-1:0] mac_txc,
    output logic [DW-1:0]    tx_data,
    output logic [LANES-1:0] tx_ctrl
);
    typedef struct packed {
        logic [DW-1:0]    data;
        logic [LANES-1:0] ctrl;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = '{data: mac_txd, ctrl: mac_txc};
        case (link_next)
            LINK_LOCAL: begin
                tx_d.data            = '0;
                tx_d.data[7:0]       = SEQ_CHAR;
                tx_d.data[DW-1 -: 8] = CODE_REMOTE;
                tx_d.ctrl            = {{(LANES-1){1'b0}}, 1'b1};
            end
            LINK_REMOTE: begin
                tx_d.data = {LANES{IDLE_CHAR}};
                tx_d.ctrl = '1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{data: {LANES{IDLE_CHAR}}, ctrl: '1};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_data = tx_q.data;
    assign tx_ctrl = tx_q.ctrl;
endmodule

// File: rtl/link_fault_ctrl.sv
module link_fault_ctrl
    import lfc_pkg::*;
#(
    parameter int QUAL_CNT  = 4,
    parameter int CLEAR_GAP = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] rx_data,
    input  logic [3:0]  rx_ctrl,
    input  logic [31:0] mac_txd,
    input  logic [3:0]  mac_txc,
    output logic [31:0] tx_data,
    output logic [3:0]  tx_ctrl,
    output logic        local_fault,
    output logic        remote_fault
);
    seq_e  kind;
    link_e link_next;
    link_e link_cur;

    lfc_seq_decode u_decode (
        .rx_data (rx_data),
        .rx_ctrl (rx_ctrl),
        .kind    (kind)
    );

    lfc_fault_fsm #(
        .QUAL_CNT  (QUAL_CNT),
        .CLEAR_GAP (CLEAR_GAP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .link_next (link_next),
        .link_cur  (link_cur)
    );

    lfc_tx_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_next (link_next),
        .mac_txd   (mac_txd),
        .mac_txc   (mac_txc),
        .tx_data   (tx_data),
        .tx_ctrl   (tx_ctrl)
    );

    assign local_fault  = (link_cur == LINK_LOCAL);
    assign remote_fault = (link_cur == LINK_REMOTE);
endmodule

// File: rtl/link_fault_ctrl_checker.sv
module link_fault_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rx_data,
    input logic [3:0]  rx_ctrl,
    input logic [31:0] mac_txd,
    input logic [3:0]  mac_txc,
    input logic [31:0] tx_data,
    input logic [3:0]  tx_ctrl,
    input logic        local_fault,
    input logic        remote_fault
);
    localparam logic [31:0] LF_WORD   = 32'h0100009C;
    localparam logic [31:0] RF_WORD   = 32'h0200009C;
    localparam logic [31:0] IDLE_WORD = 32'h07070707;

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(local_fault && remote_fault));

    p_local_sends_rf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        local_fault |-> (tx_data == RF_WORD && tx_ctrl == 4'b0001));

    p_remote_sends_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        remote_fault |-> (tx_data == IDLE_WORD && tx_ctrl == 4'hF));

    p_ok_passes_mac_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_fault && !remote_fault && $past(rst_n))
        |-> (tx_data == $past(mac_txd) && tx_ctrl == $past(mac_txc)));

    p_local_rise_on_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(local_fault) && $past(rst_n))
        |-> $past(rx_data == LF_WORD && rx_ctrl == 4'b0001));

    p_remote_rise_on_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(remote_fault) && $past(rst_n))
        |-> $past(rx_data == RF_WORD && rx_ctrl == 4'b0001));
endmodule

bind link_fault_ctrl link_fault_ctrl_checker u_chk (.*);

// File: tb/tb_link_fault_ctrl.sv
module tb_link_fault_ctrl;
    localparam logic [31:0] LF_WORD   = 32'h0100009C;
    localparam logic [31:0] RF_WORD   = 32'h0200009C;
    localparam logic [31:0] IDLE_WORD = 32'h07070707;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_data = IDLE_WORD;
    logic [3:0]  rx_ctrl = 4'hF;
    logic [31:0] mac_txd = IDLE_WORD;
    logic [3:0]  mac_txc = 4'hF;
    logic [31:0] tx_data;
    logic [3:0]  tx_ctrl;
    logic        local_fault;
    logic        remote_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_fault_ctrl dut (
        .clk (clk), .rst_n (rst_n),
        .rx_data (rx_data), .rx_ctrl (rx_ctrl),
        .mac_txd (mac_txd), .mac_txc (mac_txc),
        .tx_data (tx_data), .tx_ctrl (tx_ctrl),
        .local_fault (local_fault), .remote_fault (remote_fault)
    );

    typedef struct packed {
        logic [31:0] rxd;
        logic [3:0]  rxc;
        logic [31:0] md;
        logic [3:0]  mc;
        logic        lf;
        logic        rf;
        logic [31:0] td;
        logic [3:0]  tc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{IDLE_WORD,     4'hF,    32'hA1A2A3A4, 4'h0, 1'b0, 1'b0, 32'hA1A2A3A4, 4'h0},
        '{LF_WORD,       4'b0001, 32'hB1B2B3B4, 4'h0, 1'b0, 1'b0, 32'hB1B2B3B4, 4'h0},
        '{LF_WORD,       4'b0001, 32'hC1C2C3FB, 4'h1, 1'b0, 1'b0, 32'hC1C2C3FB, 4'h1},
        '{LF_WORD,       4'b0001, 32'hD1D2D3D4, 4'h0, 1'b0, 1'b0, 32'hD1D2D3D4, 4'h0},
        '{LF_WORD,       4'b0001, 32'hE1E2E3E4, 4'h0, 1'b1, 1'b0, RF_WORD,      4'b0001},
        '{IDLE_WORD,     4'hF,    32'hF1F2F3F4, 4'h0, 1'b1, 1'b0, RF_WORD,      4'b0001},
        '{RF_WORD,       4'b0001, 32'h11111111, 4'h0, 1'b1, 1'b0, RF_WORD,      4'b0001},
        '{RF_WORD,       4'b0001, 32'h22222222, 4'h0, 1'b1, 1'b0, RF_WORD,      4'b0001},
        '{RF_WORD,       4'b0001, 32'h33333333, 4'h0, 1'b1, 1'b0, RF_WORD,      4'b0001},
        '{RF_WORD,       4'b0001, 32'h44444444, 4'h0, 1'b0, 1'b1, IDLE_WORD,    4'hF},
        '{LF_WORD,       4'b0011, 32'h55555555, 4'h0, 1'b0, 1'b1, IDLE_WORD,    4'hF},
        '{32'h0100019C,  4'b0001, 32'h66666666, 4'h0, 1'b0, 1'b1, IDLE_WORD,    4'hF}
    };

    function automatic string vec_tag(int i);
        if (i <= 3)      return "R8 pass-through before fourth set, R2";
        else if (i == 4) return "R2 fourth local set, R6";
        else if (i <= 8) return "R4 other type restarts count, R6";
        else if (i == 9) return "R4 remote run completes, R7";
        else             return "R1 malformed set ignored, R7";
    endfunction

    task automatic check(string tag, logic lf, logic rf, logic [31:0] td, logic [3:0] tc);
        checks++;
        if (local_fault !== lf || remote_fault !== rf || tx_data !== td || tx_ctrl !== tc) begin
            errors++;
            $display("FAIL %s: got lf=%0b rf=%0b tx=%h/%h, expected lf=%0b rf=%0b tx=%h/%h",
                     tag, local_fault, remote_fault, tx_data, tx_ctrl, lf, rf, td, tc);
        end
    endtask

    task automatic check_flags(string tag, logic lf, logic rf);
        checks++;
        if (local_fault !== lf || remote_fault !== rf) begin
            errors++;
            $display("FAIL %s: got lf=%0b rf=%0b, expected lf=%0b rf=%0b",
                     tag, local_fault, remote_fault, lf, rf);
        end
    endtask

    task automatic step(logic [31:0] rd, logic [3:0] rc, logic [31:0] md, logic [3:0] mc);
        rx_data = rd; rx_ctrl = rc; mac_txd = md; mac_txc = mc;
        @(posedge clk);
        #1;
    endtask

    task automatic idles(int n);
        for (int k = 0; k < n; k++) step(IDLE_WORD, 4'hF, 32'h0, 4'h0);
    endtask

    task automatic lfs(int n);
        for (int k = 0; k < n; k++) step(LF_WORD, 4'b0001, 32'h0, 4'h0);
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", 1'b0, 1'b0, IDLE_WORD, 4'hF);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].rxd, VECS[i].rxc, VECS[i].md, VECS[i].mc);
            check(vec_tag(i), VECS[i].lf, VECS[i].rf, VECS[i].td, VECS[i].tc);
        end

        // R5: two non-fault words so far since last remote set; 125 more keeps fault
        idles(125);
        check_flags("R5 remote held after 127 quiet words", 1'b0, 1'b1);
        step(IDLE_WORD, 4'hF, 32'hCAFEF00D, 4'b1000);
        check("R5 cleared on 128th quiet word, R8 pass", 1'b0, 1'b0, 32'hCAFEF00D, 4'b1000);

        // R2: three sets then quiet never raise a fault
        lfs(3);
        check_flags("R2 three local sets insufficient", 1'b0, 1'b0);
        idles(128);

        // R3: gap of 127 keeps the run
        lfs(1);
        idles(127);
        lfs(2);
        check_flags("R3 127-word gap, third set", 1'b0, 1'b0);
        lfs(1);
        check_flags("R3 127-word gap accepted", 1'b1, 1'b0);
        idles(128);
        check_flags("R5 local cleared", 1'b0, 1'b0);

        // R3: gap of 128 restarts the run
        lfs(1);
        idles(128);
        lfs(3);
        check_flags("R3 128-word gap restarts count", 1'b0, 1'b0);
        step(LF_WORD, 4'b0001, 32'h0, 4'h0);
        check("R3 new run complete, R6", 1'b1, 1'b0, RF_WORD, 4'b0001);
        idles(128);

        // R4: interleaved remote set restarts the local count
        lfs(2);
        step(RF_WORD, 4'b0001, 32'h0, 4'h0);
        lfs(3);
        check_flags("R4 mixed run not qualified", 1'b0, 1'b0);
        lfs(1);
        check_flags("R4 fourth after restart", 1'b1, 1'b0);

        // R9: asynchronous reset mid-fault
        #1 rst_n = 1'b0;
        #0.5;
        check("R9 async reset during fault", 1'b0, 1'b0, IDLE_WORD, 4'hF);
        @(posedge clk);
        #1 rst_n = 1'b1;
        step(IDLE_WORD, 4'hF, 32'h12345678, 4'h0);
        check("R9 after reset, R8 pass", 1'b0, 1'b0, 32'h12345678, 4'h0);
        check_flags("R10 flags exclusive", 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule